// File: doc/BRIEF.md
# Overflow-Triggered Trace Sampler

This block takes program-counter samples for one hardware thread without any interrupt. Once it is switched on and put in trace mode, a period counter counts processor cycles, starting from a software-chosen load value. Each time the counter overflows, the block captures the thread's program counter and the number of cycles it has counted since tracing began. It reloads the period counter and writes the two values as a 16-byte record into a circular buffer in memory. When the buffer fills, writing goes back to the start of the buffer without any signal.

Configuration comes from two 64-bit words held outside the block: a base/mode word and a trace control word. Both use MSB-first bit numbering, so "bit k" means vector index 63-k. Records leave through a valid/ready write port. Only one record can be in flight at a time. If the sink holds `wr_ready` low for long enough that a further overflow occurs, that sample is lost and a saturating drop counter advances.

Top module: `trace_sampler`

## Requirements
- R1: After reset, `wr_valid` is 0 and `drop_count` is 0.
- R2: Tracing is active only when base bit 0 (index 63, enable) and base bit 1 (index 62, 1 = trace, 0 = accumulation) are both 1. While tracing is inactive, no record is started and the period and cycle counters restart.
- R3: The load value is the trace word's bits 0..31 (indices 63:32). An overflow occurs every 2^32 - load active cycles, and the counter reloads the load value each time.
- R4: A record is two beats. The first beat carries `pc_in` as sampled in the overflow cycle. The second beat carries the count of active cycles since tracing began, including the overflow cycle.
- R5: The buffer base is base bits 8..50 (indices 55:13), used in place as address bits 55:13, with all other bits 0. The first beat goes to base + offset and the second to base + offset + 8. The offset grows by 16 each time a record completes.
- R6: The size code is trace bits 48..50 (indices 15:13). Code n gives a buffer of 4096 << n bytes. The offset wraps to 0 at the buffer end without any signal.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R8: An overflow that occurs while a record is in flight is dropped. `drop_count` then increments, saturating at all ones, and the period counter still reloads.
- R9: A record already in flight completes even if tracing is turned off. Once tracing is inactive, the offset returns to 0.
- R10: All trace-word bits other than the load and size fields are ignored. These include the event select bits, because the event is always cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_reg | input | 64 | Base/mode word: enable, mode and buffer base |
| trace_ctl | input | 64 | Trace word: load value, size code, ignored event select |
| pc_in | input | 64 | Current program counter of the thread |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Sink accepts the beat on this edge |
| wr_addr | output | 64 | Byte address of the beat |
| wr_data | output | 64 | Beat data: PC first, then cycle count |
| drop_count | output | 8 | Saturating count of lost samples |

## Verification
The bench targets the wrap from the last 16-byte slot back to the base. A design with an off-by-one mask would write past the buffer or wrap too early. It checks that the cycle count in each record is an exact multiple of the period and that the captured PC belongs to the same cycle. A design that dropped the reload or sampled one cycle late would show a count or PC that does not match. Long stalls on `wr_ready` check that the beat stays stable, that exactly the overflows during the stall are counted, and that the counter stops at 255 rather than wrapping to zero. Turning tracing off in the middle of a record checks that the record still completes and that the next record starts again at the buffer base.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int WORD_W = 64;

  // MSB-first numbering: bit k lives at vector index WORD_W-1-k
  function automatic int msb_idx(input int k);
    return WORD_W - 1 - k;
  endfunction

  localparam int EN_IDX      = msb_idx(0);
  localparam int MODE_IDX    = msb_idx(1);
  localparam int ADDR_HI_IDX = msb_idx(8);
  localparam int ADDR_LO_IDX = msb_idx(50);
  localparam int SIZE_HI_IDX = msb_idx(48);
  localparam int SIZE_LO_IDX = msb_idx(50);

  localparam int REC_BEAT_BYTES = 8;
  localparam int REC_BYTES      = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PC   = 2'd1,
    ST_CNT  = 2'd2
  } wr_state_e;
endpackage

// File: rtl/trace_cfg_decode.sv
module trace_cfg_decode
  import trace_pkg::*;
#(
  parameter int LOAD_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [WORD_W-1:0] base_reg,
  input  logic [WORD_W-1:0] trace_ctl,
  output logic              active,
  output logic [WORD_W-1:0] base_addr,
  output logic [LOAD_W-1:0] load_val,
  output logic [SIZE_W-1:0] size_code
);
  localparam int LOAD_LO = WORD_W - LOAD_W;

  always_comb begin
    active    = base_reg[EN_IDX] & base_reg[MODE_IDX];
    base_addr = '0;
    base_addr[ADDR_HI_IDX:ADDR_LO_IDX] = base_reg[ADDR_HI_IDX:ADDR_LO_IDX];
    load_val  = trace_ctl[WORD_W-1:LOAD_LO];
    size_code = trace_ctl[SIZE_LO_IDX +: SIZE_W];
  end

  // event select and reserved fields are not decoded: event is fixed to cycles
  logic unused_fields;
  assign unused_fields = ^{base_reg[WORD_W-3:ADDR_HI_IDX+1], base_reg[ADDR_LO_IDX-1:0],
                           trace_ctl[LOAD_LO-1:SIZE_LO_IDX+SIZE_W], trace_ctl[SIZE_LO_IDX-1:0]};
endmodule

// File: rtl/trace_period_ctr.sv
module trace_period_ctr #(
  parameter int LOAD_W = 32,
  parameter int EVT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [LOAD_W-1:0] load_val,
  output logic              ovf,
  output logic [EVT_W-1:0]  evt_now
);
  logic              armed;
  logic [LOAD_W-1:0] cnt_q;
  logic [LOAD_W-1:0] cnt_eff;
  logic [EVT_W-1:0]  evt_q;

  // first active cycle starts from the load value, not stale state
  assign cnt_eff = armed ? cnt_q : load_val;
  assign ovf     = active && (cnt_eff == '1);
  assign evt_now = evt_q + EVT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt_q <= '0;
      evt_q <= '0;
    end else if (!active) begin
      armed <= 1'b0;
      cnt_q <= load_val;
      evt_q <= '0;
    end else begin
      armed <= 1'b1;
      evt_q <= evt_now;
      cnt_q <= ovf ? load_val : cnt_eff + LOAD_W'(1);
    end
  end
endmodule

// File: rtl/trace_rec_writer.sv
module trace_rec_writer
  import trace_pkg::*;
#(
  parameter int SIZE_W  = 3,
  parameter int MIN_LG  = 12,
  parameter int DROP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              ovf,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [WORD_W-1:0] evt_now,
  input  logic [WORD_W-1:0] base_addr,
  input  logic [SIZE_W-1:0] size_code,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [DROP_W-1:0] drop_count
);
  localparam int OFF_W = MIN_LG + (1 << SIZE_W) - 1;

  wr_state_e         state_q;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W-1:0]  size_mask;
  logic [OFF_W-1:0]  off_step;
  logic [WORD_W-1:0] rec_addr_q;
  logic [WORD_W-1:0] rec_pc_q;
  logic [WORD_W-1:0] rec_cnt_q;

  assign size_mask = (OFF_W'(1) << (MIN_LG + int'(size_code))) - OFF_W'(1);
  assign off_step  = (off_q + OFF_W'(REC_BYTES)) & size_mask;

  assign wr_valid = (state_q != ST_IDLE);
  assign wr_addr  = (state_q == ST_CNT) ? rec_addr_q + WORD_W'(REC_BEAT_BYTES) : rec_addr_q;
  assign wr_data  = (state_q == ST_CNT) ? rec_cnt_q : rec_pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      off_q      <= '0;
      rec_addr_q <= '0;
      rec_pc_q   <= '0;
      rec_cnt_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ovf) begin
            rec_addr_q <= base_addr + WORD_W'(off_q & size_mask);
            rec_pc_q   <= pc_in;
            rec_cnt_q  <= evt_now;
            state_q    <= ST_PC;
          end else if (!active) begin
            off_q <= '0;
          end
        end
        ST_PC: begin
          if (wr_ready) state_q <= ST_CNT;
        end
        ST_CNT: begin
          if (wr_ready) begin
            state_q <= ST_IDLE;
            off_q   <= active ? off_step : '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_count <= '0;
    end else if (ovf && (state_q != ST_IDLE) && (drop_count != '1)) begin
      drop_count <= drop_count + DROP_W'(1);
    end
  end
endmodule

// File: rtl/trace_sampler.sv
module trace_sampler
  import trace_pkg::*;
#(
  parameter int LOAD_W = 32,
  parameter int SIZE_W = 3,
  parameter int MIN_LG = 12,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       base_reg,
  input  logic [63:0]       trace_ctl,
  input  logic [63:0]       pc_in,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [63:0]       wr_addr,
  output logic [63:0]       wr_data,
  output logic [DROP_W-1:0] drop_count
);
  logic              active;
  logic [WORD_W-1:0] base_addr;
  logic [LOAD_W-1:0] load_val;
  logic [SIZE_W-1:0] size_code;
  logic              ovf;
  logic [WORD_W-1:0] evt_now;

  trace_cfg_decode #(.LOAD_W(LOAD_W), .SIZE_W(SIZE_W)) u_dec (
    .base_reg  (base_reg),
    .trace_ctl (trace_ctl),
    .active    (active),
    .base_addr (base_addr),
    .load_val  (load_val),
    .size_code (size_code)
  );

  trace_period_ctr #(.LOAD_W(LOAD_W), .EVT_W(WORD_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .load_val (load_val),
    .ovf      (ovf),
    .evt_now  (evt_now)
  );

  trace_rec_writer #(.SIZE_W(SIZE_W), .MIN_LG(MIN_LG), .DROP_W(DROP_W)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (active),
    .ovf        (ovf),
    .pc_in      (pc_in),
    .evt_now    (evt_now),
    .base_addr  (base_addr),
    .size_code  (size_code),
    .wr_ready   (wr_ready),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .drop_count (drop_count)
  );
endmodule

// File: rtl/trace_sampler_chk.sv
module trace_sampler_chk #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       base_reg,
  input logic [63:0]       trace_ctl,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [63:0]       wr_addr,
  input logic [63:0]       wr_data,
  input logic [DROP_W-1:0] drop_count
);
  logic        cfg_on;
  logic [63:0] chk_base;
  logic [63:0] chk_size;

  assign cfg_on   = base_reg[63] & base_reg[62];
  assign chk_base = base_reg & 64'h00FF_FFFF_FFFF_E000;
  assign chk_size = 64'd4096 << trace_ctl[15:13];

  // R7: a stalled beat keeps valid, address and data
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R4/R5: accepted first beat is followed at once by the second at +8
  a_r5_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && (wr_addr[3] == 1'b0) |=> wr_valid && (wr_addr == $past(wr_addr) + 64'd8));

  // R2: with tracing off and nothing in flight, no beat appears
  a_r2_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_on && !wr_valid |=> !wr_valid);

  // R8: the drop counter never goes down and moves only while a record is in flight
  a_r8_drop_mono: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> drop_count >= $past(drop_count));
  a_r8_drop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> $past(wr_valid));

  // R6: a fresh record lands inside the configured window
  a_r6_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !$past(wr_valid) && $stable(base_reg) && $stable(trace_ctl)
      |-> ((wr_addr - chk_base) < chk_size) && (wr_addr[3:0] == 4'd0));
endmodule

bind trace_sampler trace_sampler_chk #(.DROP_W(DROP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_reg   (base_reg),
  .trace_ctl  (trace_ctl),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .drop_count (drop_count)
);

// File: tb/tb_trace_sampler.sv
module tb_trace_sampler;
  localparam logic [63:0] BASE = 64'h0000_1234_5670_0000;
  localparam logic [63:0] PCB  = 64'h0000_7F00_0000_1000;
  localparam logic [31:0] LD8  = 32'hFFFF_FFF8;   // period of 8 cycles
  localparam longint      PER  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] base_reg = '0;
  logic [63:0] trace_ctl = '0;
  logic [63:0] pc_in;
  logic        wr_ready = 1'b0;
  logic        wr_valid;
  logic [63:0] wr_addr;
  logic [63:0] wr_data;
  logic [7:0]  drop_count;

  int     n_chk = 0;
  int     n_fail = 0;
  longint acyc = 0;
  longint tcyc = 0;

  trace_sampler dut (
    .clk(clk), .rst_n(rst_n), .base_reg(base_reg), .trace_ctl(trace_ctl),
    .pc_in(pc_in), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .drop_count(drop_count)
  );

  always #10 clk = ~clk;

  // PC presented in the Nth active cycle is PCB + 4*N
  assign pc_in = PCB + 64'(4 * (acyc + 1));
  always @(posedge clk) begin
    tcyc <= tcyc + 1;
    if (rst_n && base_reg[63] && base_reg[62]) acyc <= acyc + 1;
    else acyc <= 0;
  end

  always @(posedge clk) begin
    if (tcyc > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", tcyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input bit en, input bit trc, input logic [2:0] sz, input logic [15:0] junk);
    @(negedge clk);
    base_reg  = BASE | {en, trc, 62'h0} | 64'h0000_0000_0000_0ABC;
    trace_ctl = {LD8, junk, 16'h0000} | {48'h0, sz, 13'h1A5A};
  endtask

  task automatic get_beat(output logic [63:0] a, output logic [63:0] d);
    wr_ready = 1'b1;
    while (!wr_valid) @(negedge clk);
    a = wr_addr;
    d = wr_data;
    @(negedge clk);
  endtask

  task automatic get_rec(output logic [63:0] a0, output logic [63:0] pc, output logic [63:0] a1, output logic [63:0] c);
    get_beat(a0, pc);
    get_beat(a1, c);
  endtask

  task automatic restart(input logic [2:0] sz, input logic [15:0] junk);
    cfg(1'b0, 1'b0, sz, junk);
    repeat (4) @(negedge clk);
    cfg(1'b1, 1'b1, sz, junk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(wr_valid == 1'b0, "R1 valid", 64'(wr_valid), 64'd0);
    check(drop_count == 8'd0, "R1 drops", 64'(drop_count), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_inactive();
    bit seen;
    seen = 1'b0;
    wr_ready = 1'b1;
    cfg(1'b1, 1'b0, 3'd0, 16'h0);   // enabled, accumulation mode
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (wr_valid) seen = 1'b1; end
    check(!seen, "R2 accumulation mode", 64'(seen), 64'd0);
    seen = 1'b0;
    cfg(1'b0, 1'b1, 3'd0, 16'h0);   // trace mode, disabled
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (wr_valid) seen = 1'b1; end
    check(!seen, "R2 disabled", 64'(seen), 64'd0);
  endtask

  task automatic t_basic(input logic [15:0] junk);
    logic [63:0] a0, pc, a1, c;
    restart(3'd0, junk);
    for (int k = 1; k <= 3; k++) begin
      get_rec(a0, pc, a1, c);
      check(c == 64'(PER * k), "R3 R10 period count", c, 64'(PER * k));
      check(pc == PCB + 64'(4 * PER * k), "R4 pc sample", pc, PCB + 64'(4 * PER * k));
      check(a0 == BASE + 64'(16 * (k - 1)), "R5 first beat addr", a0, BASE + 64'(16 * (k - 1)));
      check(a1 == a0 + 64'd8, "R5 second beat addr", a1, a0 + 64'd8);
    end
  endtask

  task automatic t_wrap();
    logic [63:0] a0, pc, a1, c;
    restart(3'd0, 16'h0);
    for (int k = 1; k <= 257; k++) begin
      get_rec(a0, pc, a1, c);
      if (k == 256) check(a0 == BASE + 64'd4080, "R6 last slot", a0, BASE + 64'd4080);
      if (k == 257) begin
        check(a0 == BASE, "R6 wrap to base", a0, BASE);
        check(c == 64'(PER * 257), "R3 count after wrap", c, 64'(PER * 257));
      end
    end
    restart(3'd1, 16'h0);            // 8 KiB buffer: slot 256 is still inside
    for (int k = 1; k <= 257; k++) get_rec(a0, pc, a1, c);
    check(a0 == BASE + 64'd4096, "R6 larger size code", a0, BASE + 64'd4096);
  endtask

  task automatic t_stall();
    logic [63:0] a0, d0, a, d, a1, c, pc;
    logic [7:0]  drop0;
    bit          held;
    wr_ready = 1'b0;
    restart(3'd0, 16'h0);
    while (!wr_valid) @(negedge clk);
    a0 = wr_addr; d0 = wr_data; drop0 = drop_count; held = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!(wr_valid && wr_addr == a0 && wr_data == d0)) held = 1'b0;
    end
    check(held, "R7 beat held under stall", wr_addr, a0);
    check(a0 == BASE, "R9 offset restarted", a0, BASE);
    get_beat(a, d);
    check(d == d0, "R7 stalled data delivered", d, d0);
    get_beat(a, d);
    check(d == 64'(PER), "R4 count beat", d, 64'(PER));
    get_rec(a0, pc, a1, c);
    check(c == 64'(4 * PER), "R8 next kept sample", c, 64'(4 * PER));
    check(drop_count == drop0 + 8'd2, "R8 drops counted", 64'(drop_count), 64'(drop0 + 8'd2));
  endtask

  task automatic t_saturate();
    logic [63:0] a0, pc, a1, c;
    wr_ready = 1'b0;
    restart(3'd0, 16'h0);
    repeat (2200) @(negedge clk);
    check(drop_count == 8'hFF, "R8 saturation", 64'(drop_count), 64'hFF);
    get_rec(a0, pc, a1, c);
    get_rec(a0, pc, a1, c);
    check(drop_count == 8'hFF, "R8 stays saturated", 64'(drop_count), 64'hFF);
  endtask

  task automatic t_off_midrec();
    logic [63:0] a0, d0, a, d, pc, a1, c;
    bit held;
    wr_ready = 1'b0;
    restart(3'd0, 16'h0);
    while (!wr_valid) @(negedge clk);
    a0 = wr_addr; d0 = wr_data; held = 1'b1;
    cfg(1'b0, 1'b0, 3'd0, 16'h0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!(wr_valid && wr_addr == a0 && wr_data == d0)) held = 1'b0;
    end
    check(held, "R9 record survives disable", wr_addr, a0);
    get_beat(a, d);
    get_beat(a, d);
    check(d == 64'(PER), "R9 record completes", d, 64'(PER));
    repeat (3) @(negedge clk);
    check(!wr_valid, "R2 quiet after disable", 64'(wr_valid), 64'd0);
    cfg(1'b1, 1'b1, 3'd0, 16'h0);
    get_rec(a0, pc, a1, c);
    check(a0 == BASE, "R9 offset back to base", a0, BASE);
    check(c == 64'(PER), "R9 count restarted", c, 64'(PER));
  endtask

  initial begin
    t_reset();
    t_inactive();
    t_basic(16'hA5C3);
    t_basic(16'h5A3C);
    t_wrap();
    t_stall();
    t_off_midrec();
    t_saturate();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule